// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers every reset request of a small microcontroller and turns them into two reset outputs. The first is a system reset that returns the CPU and all peripherals to their defaults. The second is a CPU reset for the processor alone, which peripheral state does not follow. The requests come from power-on, an active-low external pin, watchdog overflow, a low-voltage detector, a program counter that leaves the program area (burn-out) and a ROM failure. Every output assertion lasts a fixed minimum number of slow-oscillator cycles and ends in step with that clock.

The external pin and the low-voltage input are brought into the clock domain and filtered, each by its own rule. The pin must stay low across a number of microsecond ticks. The detector must stay high for a number of consecutive clock cycles. A small register bus gives software a sticky four-bit record of which sources fired. The same bus holds an enable for the low-voltage reset, which only changes when one of two key values is written to it. Power-on and the external pin wipe the source record; the other sources add to it.

Top module: `rstHub`

## Requirements
- R1: While `porN` is low, `sysRst` and `cpuRst` are 1, the flag register reads 0000 and the low-voltage enable reads 1. After `porN` rises, `sysRst` stays high for some cycles and then falls without further requests.
- R2: `cpuRst` is 1 in every cycle in which `sysRst` is 1, so a CPU reset accompanies each system reset.
- R3: `extRstN` low while at most one `usTick` pulse is counted causes no reset. Held low across two tick pulses, it asserts `sysRst`, which stays high while the pin is held low.
- R4: An external reset clears all four flags to 0000.
- R5: The enable sits in bit 0 of address 0x304. Writing 0x5 sets it, writing 0xA clears it, and writing any other value leaves it unchanged.
- R6: A one-cycle pulse on `wdtReq`, `boReq` or `romFailReq` asserts `sysRst` after the next clock edge. It sets the matching flag at address 0x300: bit 0 watchdog, bit 2 burn-out, bit 3 ROM fail.
- R7: A write to 0x300 stores the written bits, so writing 0 clears a flag. A hardware set in the same cycle wins over a written 0.
- R8: With the enable at 1, `lvdIn` high for 4 consecutive cycles asserts `sysRst` and sets flag bit 1. High for only 3 cycles, it does neither.
- R9: A single request pulse keeps `sysRst` high for exactly 16 consecutive cycles.
- R10: While the enable is 0, `lvdIn` causes no reset and does not set flag bit 1.
- R11: A request that arrives during an active reset restarts the 16-cycle hold from that request. Flags set earlier in the same reset are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| usTick | input | 1 | One-cycle pulse every microsecond |
| extRstN | input | 1 | External reset pin, active low |
| lvdIn | input | 1 | Low-voltage detector output, active high |
| wdtReq | input | 1 | Watchdog overflow request |
| boReq | input | 1 | Program-out-of-range request |
| romFailReq | input | 1 | ROM failure request |
| busAddr | input | 12 | Register address |
| busWr | input | 1 | Write strobe |
| busWrData | input | 4 | Write data |
| busRdData | output | 4 | Read data for `busAddr` |
| sysRst | output | 1 | System reset, active high |
| cpuRst | output | 1 | CPU reset, active high |

## Verification
The hardest situations to reach are those where two events meet inside one reset window. One is a second request landing part-way through the 16-cycle hold. Another is a hardware flag set in the same cycle as a software clearing write. A third is a low-voltage pulse one cycle short of the debounce length. The stimulus reaches these with directed sequences that time a pulse a fixed number of negative edges after the first, or that drive a flag write and a request in the same cycle. Random groups of simultaneous watchdog, burn-out and ROM-fail pulses then check that the flags accumulate and that the hold length stays fixed.

// File: rtl/rstHubPkg.sv
package rstHubPkg;
  typedef struct packed {
    logic setWdt;
    logic setLvr;
    logic setBo;
    logic setRom;
    logic clrAll;
  } flagStrobeT;
endpackage

// File: rtl/rstHubCtl.sv
module rstHubCtl
  import rstHubPkg::*;
#(
  parameter int EXT_TICKS   = 2,
  parameter int LVD_CYCLES  = 4,
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       usTick,
  input  logic       extRstN,
  input  logic       lvdIn,
  input  logic       wdtReq,
  input  logic       boReq,
  input  logic       romReq,
  input  logic       lvrEn,
  output flagStrobeT strobe,
  output logic       sysRst
);
  localparam int EXT_W  = $clog2(EXT_TICKS + 1);
  localparam int LVD_W  = $clog2(LVD_CYCLES + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic [1:0] extSync, lvdSync;
  logic [EXT_W-1:0] extCnt;
  logic [LVD_W-1:0] lvdCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic extLow, lvdHigh, extTrig, lvdTrig, anyReq;

  // two-stage synchronisers for the asynchronous inputs
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      extSync <= 2'b11;
      lvdSync <= 2'b00;
    end else begin
      extSync <= {extSync[0], extRstN};
      lvdSync <= {lvdSync[0], lvdIn};
    end
  end

  assign extLow  = !extSync[1];
  assign lvdHigh = lvdSync[1];

  // pin filter counts microsecond ticks while low
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) extCnt <= '0;
    else if (!extLow) extCnt <= '0;
    else if (usTick && extCnt != EXT_W'(EXT_TICKS)) extCnt <= extCnt + 1'b1;
  end
  assign extTrig = extLow && (extCnt == EXT_W'(EXT_TICKS));

  // detector filter counts clock cycles while high and enabled
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) lvdCnt <= '0;
    else if (!lvrEn || !lvdHigh) lvdCnt <= '0;
    else if (lvdCnt != LVD_W'(LVD_CYCLES - 1)) lvdCnt <= lvdCnt + 1'b1;
  end
  assign lvdTrig = lvrEn && lvdHigh && (lvdCnt == LVD_W'(LVD_CYCLES - 1));

  assign anyReq = extTrig || lvdTrig || wdtReq || boReq || romReq;

  // hold timer, restarted by every request
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      holdCnt <= HOLD_W'(HOLD_CYCLES);
      sysRst  <= 1'b1;
    end else begin
      sysRst <= anyReq || (holdCnt > HOLD_W'(1));
      if (anyReq) holdCnt <= HOLD_W'(HOLD_CYCLES);
      else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.setWdt = wdtReq;
    strobe.setLvr = lvdTrig;
    strobe.setBo  = boReq;
    strobe.setRom = romReq;
    strobe.clrAll = extTrig;
  end

  assert_req_starts_R6: assert property (@(posedge clk) disable iff (!porN)
    anyReq |=> sysRst);
  assert_release_after_hold_R9: assert property (@(posedge clk) disable iff (!porN)
    $fell(sysRst) |-> ($past(holdCnt) == HOLD_W'(1)) && !$past(anyReq));
  assert_lvd_idle_R10: assert property (@(posedge clk) disable iff (!porN)
    !lvrEn |=> (lvdCnt == '0));
  assert_ext_wait_R3: assert property (@(posedge clk) disable iff (!porN)
    $rose(extTrig) |-> extLow && $past(extLow));
endmodule

// File: rtl/rstHubDp.sv
module rstHubDp
  import rstHubPkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 4,
  parameter logic [11:0] FLAG_ADDR = 12'h300,
  parameter logic [11:0] EN_ADDR   = 12'h304,
  parameter logic [3:0]  KEY_SET   = 4'h5,
  parameter logic [3:0]  KEY_CLR   = 4'hA
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  flagStrobeT        strobe,
  output logic              lvrEn
);
  logic [3:0] flags, flagsNxt;
  logic flagWr, enWr;

  assign flagWr = busWr && (busAddr == ADDR_W'(FLAG_ADDR));
  assign enWr   = busWr && (busAddr == ADDR_W'(EN_ADDR));

  always_comb begin
    flagsNxt = flags;
    if (flagWr) flagsNxt = busWrData[3:0];
    flagsNxt = flagsNxt | {strobe.setRom, strobe.setBo, strobe.setLvr, strobe.setWdt};
    if (strobe.clrAll) flagsNxt = '0;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      flags <= '0;
      lvrEn <= 1'b1;
    end else begin
      flags <= flagsNxt;
      if (enWr && busWrData[3:0] == KEY_SET) lvrEn <= 1'b1;
      else if (enWr && busWrData[3:0] == KEY_CLR) lvrEn <= 1'b0;
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(FLAG_ADDR)) busRdData[3:0] = flags;
    else if (busAddr == ADDR_W'(EN_ADDR)) busRdData[0] = lvrEn;
  end

  assert_key_only_R5: assert property (@(posedge clk) disable iff (!porN)
    (lvrEn != $past(lvrEn)) |-> $past(enWr && (busWrData[3:0] == KEY_SET || busWrData[3:0] == KEY_CLR)));
  assert_wdt_flag_R6: assert property (@(posedge clk) disable iff (!porN)
    (strobe.setWdt && !strobe.clrAll) |=> flags[0]);
  assert_clear_R4: assert property (@(posedge clk) disable iff (!porN)
    strobe.clrAll |=> (flags == 4'b0000));
endmodule

// File: rtl/rstHub.sv
module rstHub
  import rstHubPkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 4,
  parameter int EXT_TICKS   = 2,
  parameter int LVD_CYCLES  = 4,
  parameter int HOLD_CYCLES = 16
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              usTick,
  input  logic              extRstN,
  input  logic              lvdIn,
  input  logic              wdtReq,
  input  logic              boReq,
  input  logic              romFailReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              sysRst,
  output logic              cpuRst
);
  flagStrobeT strobe;
  logic lvrEn;

  rstHubCtl #(.EXT_TICKS(EXT_TICKS), .LVD_CYCLES(LVD_CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) uCtl (
    .clk(clk), .porN(porN), .usTick(usTick), .extRstN(extRstN), .lvdIn(lvdIn),
    .wdtReq(wdtReq), .boReq(boReq), .romReq(romFailReq), .lvrEn(lvrEn),
    .strobe(strobe), .sysRst(sysRst)
  );

  rstHubDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .porN(porN), .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
    .busRdData(busRdData), .strobe(strobe), .lvrEn(lvrEn)
  );

  // the CPU is part of every system reset
  assign cpuRst = sysRst;
endmodule

// File: tb/tb_rstHub.sv
module tb_rstHub;
  logic clk = 1'b0;
  logic porN, usTick, extRstN, lvdIn, wdtReq, boReq, romFailReq, busWr;
  logic [11:0] busAddr;
  logic [3:0] busWrData, busRdData;
  logic sysRst, cpuRst;
  int total = 0, bad = 0, cycles = 0, tickCnt = 0;
  logic [3:0] rd;
  int cnt;
  logic seen;

  always #2 clk = ~clk;

  rstHub dut (.clk(clk), .porN(porN), .usTick(usTick), .extRstN(extRstN), .lvdIn(lvdIn),
    .wdtReq(wdtReq), .boReq(boReq), .romFailReq(romFailReq), .busAddr(busAddr),
    .busWr(busWr), .busWrData(busWrData), .busRdData(busRdData), .sysRst(sysRst), .cpuRst(cpuRst));

  always @(negedge clk) begin
    tickCnt <= (tickCnt == 9) ? 0 : tickCnt + 1;
    usTick  <= (tickCnt == 9);
  end

  function automatic logic [3:0] expFlagsFn(input logic w, input logic l, input logic b, input logic r);
    return {r, b, l, w};
  endfunction

  function automatic int expHoldFn();
    return 16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [11:0] a, output logic [3:0] v);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic writeReg(input logic [11:0] a, input logic [3:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic pulse(input logic w, input logic b, input logic r);
    @(negedge clk); wdtReq = w; boReq = b; romFailReq = r;
    @(negedge clk); wdtReq = 0; boReq = 0; romFailReq = 0;
  endtask

  // counts high samples from the current negedge; also compares cpuRst (R2)
  task automatic countHigh(output int n);
    n = 0;
    while (sysRst === 1'b1 && n < 200) begin
      if (cpuRst !== 1'b1) check("R2", cpuRst, 1);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic watchIdle(input int n, output logic s);
    s = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sysRst) s = 1;
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    porN = 0; extRstN = 1; lvdIn = 0; wdtReq = 0; boReq = 0; romFailReq = 0;
    busWr = 0; busAddr = 12'h300; busWrData = 0; usTick = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sysRst", sysRst, 1);
    check("R2 cpuRst", cpuRst, 1);
    readReg(12'h300, rd); check("R1 flags", rd, 0);
    readReg(12'h304, rd); check("R1 enable", rd, 1);
    porN = 1;
    @(negedge clk);
    check("R1 held after release", sysRst, 1);
    watchIdle(20, seen);
    check("R1 released", sysRst, 0);

    // R6 / R9 single watchdog pulse
    pulse(1, 0, 0);
    countHigh(cnt);
    check("R9 hold", cnt, expHoldFn());
    readReg(12'h300, rd); check("R6 wdt flag", rd, expFlagsFn(1, 0, 0, 0));

    // R7 flag writes, hardware set beats written 0
    writeReg(12'h300, 4'hF);
    readReg(12'h300, rd); check("R7 write F", rd, 4'hF);
    writeReg(12'h300, 4'h0);
    readReg(12'h300, rd); check("R7 write 0", rd, 4'h0);
    @(negedge clk); busAddr = 12'h300; busWrData = 4'h0; busWr = 1'b1; wdtReq = 1'b1;
    @(negedge clk); busWr = 1'b0; wdtReq = 1'b0;
    readReg(12'h300, rd); check("R7 set wins", rd, 4'h1);
    watchIdle(20, seen);

    // R11 retrigger during hold
    writeReg(12'h300, 4'h0);
    pulse(1, 0, 0);
    repeat (6) @(negedge clk);
    pulse(0, 1, 0);
    countHigh(cnt);
    check("R11 restart", cnt, expHoldFn());
    readReg(12'h300, rd); check("R11 flags kept", rd, expFlagsFn(1, 0, 1, 0));

    // R8 low-voltage debounce boundary
    writeReg(12'h300, 4'h0);
    @(negedge clk); lvdIn = 1;
    repeat (3) @(negedge clk);
    lvdIn = 0;
    watchIdle(12, seen);
    check("R8 three cycles ignored", seen, 0);
    readReg(12'h300, rd); check("R8 no flag", rd, 0);
    @(negedge clk); lvdIn = 1;
    repeat (4) @(negedge clk);
    lvdIn = 0;
    watchIdle(6, seen);
    check("R8 four cycles reset", seen, 1);
    watchIdle(25, seen);
    readReg(12'h300, rd); check("R8 lvr flag", rd, expFlagsFn(0, 1, 0, 0));

    // R5 keyed enable, R10 disabled input
    writeReg(12'h300, 4'h0);
    writeReg(12'h304, 4'hA);
    readReg(12'h304, rd); check("R5 clear key", rd, 0);
    writeReg(12'h304, 4'h7);
    readReg(12'h304, rd); check("R5 other value", rd, 0);
    @(negedge clk); lvdIn = 1;
    repeat (10) @(negedge clk);
    lvdIn = 0;
    watchIdle(6, seen);
    check("R10 no reset", seen, 0);
    readReg(12'h300, rd); check("R10 no flag", rd, 0);
    writeReg(12'h304, 4'h5);
    readReg(12'h304, rd); check("R5 set key", rd, 1);
    writeReg(12'h304, 4'h0);
    readReg(12'h304, rd); check("R5 zero ignored", rd, 1);

    // R3 short pin low
    @(negedge clk); extRstN = 0;
    watchIdle(8, seen);
    extRstN = 1;
    begin
      logic s2;
      watchIdle(12, s2);
      check("R3 short low ignored", seen | s2, 0);
    end

    // R3 / R4 long pin low clears flags
    pulse(0, 0, 1);
    watchIdle(25, seen);
    readReg(12'h300, rd); check("R6 rom flag", rd, expFlagsFn(0, 0, 0, 1));
    @(negedge clk); extRstN = 0;
    repeat (40) @(negedge clk);
    check("R3 long low reset", sysRst, 1);
    extRstN = 1;
    watchIdle(30, seen);
    check("R3 released", sysRst, 0);
    readReg(12'h300, rd); check("R4 flags cleared", rd, 0);

    // random simultaneous requests
    for (int it = 0; it < 24; it++) begin
      logic [2:0] m;
      m = 3'($urandom % 8);
      if (m == 0) m = 3'b001;
      writeReg(12'h300, 4'h0);
      pulse(m[0], m[1], m[2]);
      countHigh(cnt);
      check("R9 random hold", cnt, expHoldFn());
      readReg(12'h300, rd);
      check("R6 random flags", rd, expFlagsFn(m[0], 0, m[1], m[2]));
      repeat (int'($urandom % 4)) @(negedge clk);
    end
    finishRun();
  end
endmodule